// File: doc/BRIEF.md
# Bit Test and Modify Unit

This block carries out the four bit-test operations on one operand. It reports the selected bit in a carry output. It can also set, clear or invert that bit and return the modified word for write-back. The operand is 32 bits wide in wide mode and 16 bits wide in narrow mode. The bit offset comes from a register value.

For a memory operand, a bit offset larger than the operand width reaches beyond the addressed word. The block splits such an offset into two parts: a signed byte step, which the surrounding memory stage adds to the effective address, and a bit position inside the word that is then fetched. For a register operand, the offset is simply reduced modulo the width. The block performs no memory access itself. Results are registered and appear one cycle after the input is accepted.

Top module: `bit_modify_unit`

## Requirements
- R1: `carry` holds the value of the selected operand bit before modification, for every operation.
- R2: `op` encoding: 0 test (result equals the operand), 1 set the bit, 2 clear the bit, 3 invert the bit. All other result bits equal the operand.
- R3: With `wide`=1 the bit position is `offset[4:0]`. With `wide`=0 it is `offset[3:0]`, `offset[31:16]` has no effect, and `result[31:16]` equals `operand[31:16]`.
- R4: For a memory operand with `wide`=1, `addr_adj` = floor(signed 32-bit offset / 32) * 4, in two's complement.
- R5: For a memory operand with `wide`=0, `addr_adj` = floor(signed 16-bit `offset[15:0]` / 16) * 2, sign-extended to 32 bits.
- R6: For a register operand (`in_mem`=0), `addr_adj` is 0 whatever the offset.
- R7: Outputs update at the clock edge that accepts `in_valid`. `out_valid` is high for one cycle per accepted input. `wr_en` is high in that cycle only for ops 1, 2 and 3.
- R8: After reset, all outputs are 0.
- R9: While `in_valid` is low, `carry`, `result` and `addr_adj` hold their last values, and `out_valid` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request |
| op | input | 2 | 0 test, 1 set, 2 clear, 3 invert |
| wide | input | 1 | 1: 32-bit operand, 0: 16-bit |
| in_mem | input | 1 | Operand comes from memory |
| operand | input | 32 | Operand value |
| offset | input | 32 | Bit offset register value |
| out_valid | output | 1 | Result valid |
| carry | output | 1 | Original selected bit |
| result | output | 32 | Modified operand |
| wr_en | output | 1 | Write-back request |
| addr_adj | output | 32 | Signed byte step for the address |

## Verification
The hardest behaviour to reach is the floor rounding of negative offsets. It only shows when a memory operand carries a negative offset that is not a multiple of the width, and when the most negative offset is used. The stimulus drives offsets of -1, -33, 0x80000000 and a narrow 0xFFF1 into memory operations. It also applies narrow operations with junk in the upper offset half, so that any leak of the upper bits shows up in the position or the step.

// File: rtl/bit_modify_unit.sv
module bit_modify_unit #(
  parameter int DW = 32,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    op,
  input  logic          wide,
  input  logic          in_mem,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] offset,
  output logic          out_valid,
  output logic          carry,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic [DW-1:0] addr_adj
);
  localparam int PW  = $clog2(DW);
  localparam int NPW = $clog2(NW);
  localparam int AB  = $clog2(DW / 8);
  localparam int NAB = $clog2(NW / 8);
  localparam logic [1:0] OP_TEST = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_INV = 2'd3;

  logic [PW-1:0]        pos;
  logic [DW-1:0]        mask, mod;
  logic                 bit_old;
  logic signed [DW-1:0] off_w, off_n, adj_w, adj_n;
  logic [DW-1:0]        adj;

  assign pos     = wide ? offset[PW-1:0] : {{(PW-NPW){1'b0}}, offset[NPW-1:0]};
  assign mask    = DW'(1) << pos;
  assign bit_old = |(operand & mask);

  always_comb begin
    case (op)
      OP_SET:  mod = operand | mask;
      OP_CLR:  mod = operand & ~mask;
      OP_INV:  mod = operand ^ mask;
      default: mod = operand;
    endcase
  end

  assign off_w = offset;
  assign off_n = {{(DW-NW){offset[NW-1]}}, offset[NW-1:0]};
  assign adj_w = (off_w >>> PW) <<< AB;
  assign adj_n = (off_n >>> NPW) <<< NAB;
  assign adj   = !in_mem ? '0 : (wide ? adj_w : adj_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      carry     <= 1'b0;
      result    <= '0;
      addr_adj  <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && (op != OP_TEST);
      if (in_valid) begin
        carry    <= bit_old;
        result   <= mod;
        addr_adj <= adj;
      end
    end
  end

  a_r7_write_inside_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid);
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_TEST) |=> (!wr_en && result == $past(operand)));
  a_r6_reg_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mem) |=> addr_adj == '0);
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> result[DW-1:NW] == $past(operand[DW-1:NW]));
  a_r2_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $countones(result ^ $past(operand)) <= 1);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(addr_adj) && $stable(carry)));
endmodule

// File: tb/test_bit_modify_unit.sv
module test_bit_modify_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, wide = 1'b0, in_mem = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] operand = '0, offset = '0;
  logic        out_valid, carry, wr_en;
  logic [31:0] result, addr_adj;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bit_modify_unit i_bit_modify_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
    .in_mem(in_mem), .operand(operand), .offset(offset), .out_valid(out_valid),
    .carry(carry), .result(result), .wr_en(wr_en), .addr_adj(addr_adj));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] o, input bit w, input bit m,
                     input logic [31:0] opd, input logic [31:0] off);
    longint s, q, wd;
    int p;
    logic [31:0] r, a;
    @(negedge clk);
    op = o; wide = w; in_mem = m; operand = opd; offset = off; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    wd = w ? 32 : 16;
    p  = w ? int'(off % 32) : int'(off[15:0] % 16);
    s  = w ? longint'($signed(off)) : longint'($signed(off[15:0]));
    q  = s / wd;
    if (s < 0 && (s % wd) != 0) q = q - 1;
    a  = m ? 32'(q * (wd / 8)) : 32'd0;
    r  = opd;
    if (o == 2'd1) r[p] = 1'b1;
    if (o == 2'd2) r[p] = 1'b0;
    if (o == 2'd3) r[p] = ~opd[p];
    chk({req, " R1 carry"}, {31'd0, carry}, {31'd0, opd[p]});
    chk({req, " R2 result"}, result, r);
    chk({req, " R4/R5/R6 addr_adj"}, addr_adj, a);
    chk({req, " R7 valid/wr_en"}, {30'd0, out_valid, wr_en}, {30'd0, 1'b1, o != 2'd0});
  endtask

  task automatic t_reset();
    chk("R8 reset", {out_valid, carry, wr_en}, 3'b000);
    chk("R8 reset result", result | addr_adj, 32'd0);
  endtask

  task automatic t_ops_wide();
    run("wide test", 2'd0, 1'b1, 1'b0, 32'h8000_0001, 32'd31);
    run("wide set", 2'd1, 1'b1, 1'b0, 32'h0000_0000, 32'd17);
    run("wide clear", 2'd2, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'd0);
    run("wide invert", 2'd3, 1'b1, 1'b0, 32'h1234_5678, 32'd3);
    run("R6 reg big offset", 2'd1, 1'b1, 1'b0, 32'h0, 32'h7FFF_FFE9);
  endtask

  task automatic t_ops_narrow();
    run("R3 narrow upper junk", 2'd3, 1'b0, 1'b0, 32'hDEAD_0000, 32'hABCD_0013);
    run("R3 narrow bit15", 2'd2, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_FFFF);
    run("R3 narrow test", 2'd0, 1'b0, 1'b1, 32'h5555_AAAA, 32'hFFFF_0013);
  endtask

  task automatic t_mem_steps();
    run("R4 mem +", 2'd1, 1'b1, 1'b1, 32'h0, 32'd100);
    run("R4 mem -1", 2'd0, 1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
    run("R4 mem -33", 2'd3, 1'b1, 1'b1, 32'h0, 32'hFFFF_FFDF);
    run("R4 mem min", 2'd2, 1'b1, 1'b1, 32'h1, 32'h8000_0000);
    run("R5 mem narrow neg", 2'd1, 1'b0, 1'b1, 32'h0, 32'h1234_FFF1);
    run("R5 mem narrow pos", 2'd0, 1'b0, 1'b1, 32'h0008, 32'h0000_7FF3);
  endtask

  task automatic t_idle();
    logic [31:0] r0, a0;
    logic c0;
    run("R9 setup", 2'd3, 1'b1, 1'b1, 32'h0F0F_0F0F, 32'd37);
    r0 = result; a0 = addr_adj; c0 = carry;
    @(negedge clk);
    operand = 32'hFFFF_FFFF; offset = 32'hFFFF_FFFF; op = 2'd1;
    @(negedge clk);
    chk("R9 idle strobes", {30'd0, out_valid, wr_en}, 32'd0);
    chk("R9 idle result", result, r0);
    chk("R9 idle adj", addr_adj, a0);
    chk("R9 idle carry", {31'd0, carry}, {31'd0, c0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_ops_wide();
    t_ops_narrow();
    t_mem_steps();
    t_idle();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule